// File: doc/BRIEF.md
# SPI Slave Memory Port with Per-Transaction Status

This block lets an external SPI master read and write a byte-addressed memory. The master lowers the chip select and sends a command byte. Two address bytes follow, high byte first. After that come any number of data bytes, and the chip select rises to close the transaction. Bit 7 of the command byte chooses the direction: 1 reads and 0 writes. The address steps up by one after every data byte. The command byte is also kept in a register that the rest of the chip can see.

When a transaction closes, the port folds its history into one status byte. That byte holds a ready-error flag, the parity of the data the slave sent, the parity of everything the master sent, and a three-bit data-byte count. The byte is shifted out on MISO while the master clocks in the command byte of the next transaction.

A safe-mode input limits writes to one aligned 16-byte window of memory. An enable input switches the whole port off.

The serial pins are sampled with the system clock, so SCK must run several times slower than `clk`. Each half period of SCK must last at least three `clk` cycles. The memory side is a one-cycle strobe. The memory drives read data and `mem_ready` in the same cycle as the strobe.

Top module: `spi_stat_slave`

## Requirements
- R1: The bus uses SPI mode 0 with the MSB first. The byte order is a command, then the address high byte, then the address low byte, then data. Command bit 7 = 1 means read and 0 means write. The command byte is copied to `cmd_reg` after its eighth bit, and `cmd_reg` resets to 0x00.
- R2: While the command byte is being clocked in, MISO returns the status byte of the previous enabled transaction. After reset that status byte is 0x00. Status bits 1:0 are always 0. MISO is 0 while CS_N is high.
- R3: In a write, data byte k is written to the start address + k. Each write is a single-cycle `mem_wr` strobe. `mem_rd` and `mem_wr` are never high together.
- R4: In a read, data byte k on MISO is the memory byte at the start address + k. A read issued while `mem_ready` is 0 returns 0x00.
- R5: Status bit 7 is set when `mem_ready` was 0 during any memory access the transaction issued. A read issues one access per data byte plus one access when the address completes.
- R6: Status bit 6 is the XOR of all bits of the data bytes the slave sent in full during a read. It is 0 for a write.
- R7: Status bit 5 is the XOR of all bits of every complete byte received, counting the command and address bytes.
- R8: Status bits 4:2 hold the number of complete data bytes modulo 8. A transaction with no data byte reports 111.
- R9: With safe mode on, a write goes to memory only if its address lies in the window from WIN_BASE to WIN_BASE + 15. A blocked write is dropped without a ready error, but it still counts toward R7 and R8.
- R10: With `en` at 0, a transaction has no effect. No memory access is issued, `cmd_reg` does not change, MISO stays 0, and the pending status byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Port enable |
| safe_mode | input | 1 | Limits writes to the 16-byte window |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rd | output | 1 | Read strobe, one cycle |
| mem_wr | output | 1 | Write strobe, one cycle |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with the strobe |
| mem_ready | input | 1 | Memory can complete the access this cycle |
| cmd_reg | output | 8 | Last command byte received |

## Verification
The bench uses the default parameters: a 16-bit address, WIN_BASE = 0x0040 and a 16-byte window. With a window this small, a single burst of a few bytes can start outside the window and run into it, or start inside and run out, so both edges of R9 are tested. Write and read bursts are swept from zero to ten data bytes, which takes the three-bit count of R8 through its wrap past eight. Transactions that stop after one, two or three bytes give the 111 case. Each direction is also run with the memory stalled, and one run uses a write whose bytes are all blocked, so the ready-error and parity fields are checked separately.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

  typedef enum logic [1:0] {
    PH_CMD    = 2'd0,
    PH_ADR_HI = 2'd1,
    PH_ADR_LO = 2'd2,
    PH_DATA   = 2'd3
  } phase_e;

  typedef struct packed {
    logic       rdy_err;
    logic       sent_par;
    logic       recv_par;
    logic [2:0] cnt;
    logic [1:0] rsvd;
  } stat_t;

  function automatic logic in_window(input logic [15:0] a,
                                     input logic [15:0] base,
                                     input int          lg);
    return (a >> lg) == (base >> lg);
  endfunction

endpackage

// File: rtl/spi_stat_sync.sv
// Samples the serial pins with clk and produces single-cycle edge events.
module spi_stat_sync (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_start,
  output logic cs_end,
  output logic sel,
  output logic mosi_s
);

  logic sck_q, sck_q2, cs_q, cs_q2;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= 1'b0;
      sck_q2 <= 1'b0;
      cs_q   <= 1'b1;
      cs_q2  <= 1'b1;
      mosi_s <= 1'b0;
    end else begin
      sck_q  <= sck;
      sck_q2 <= sck_q;
      cs_q   <= cs_n;
      cs_q2  <= cs_q;
      mosi_s <= mosi;
    end
  end

  assign sck_rise = sck_q & ~sck_q2;
  assign sck_fall = ~sck_q & sck_q2;
  assign cs_start = ~cs_q & cs_q2;
  assign cs_end   = cs_q & ~cs_q2;
  assign sel      = ~cs_q;

endmodule

// File: rtl/spi_stat_frame.sv
// Bit and byte framing: receive shifter, bit counter, transaction phase.
module spi_stat_frame
  import spi_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       rise,
  input  logic       sel,
  input  logic       mosi_s,
  output logic       byte_done,
  output logic [7:0] byte_val,
  output phase_e     ph,
  output logic [2:0] bit_cnt
);

  logic [7:0] rx_sh;

  assign byte_val  = {rx_sh[6:0], mosi_s};
  assign byte_done = sel & rise & (bit_cnt == 3'd7);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sh   <= '0;
      bit_cnt <= '0;
      ph      <= PH_CMD;
    end else if (start) begin
      bit_cnt <= '0;
      ph      <= PH_CMD;
    end else if (sel && rise) begin
      rx_sh   <= byte_val;
      bit_cnt <= bit_cnt + 3'd1;
      if (bit_cnt == 3'd7 && ph != PH_DATA)
        ph <= phase_e'(ph + 2'd1);
    end
  end

endmodule

// File: rtl/spi_stat_tally.sv
// Collects the per-transaction summary and latches it when chip select rises.
module spi_stat_tally
  import spi_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       finish,
  input  logic       byte_done,
  input  logic [7:0] byte_val,
  input  logic       is_data,
  input  logic       is_read,
  input  logic [7:0] sent_byte,
  input  logic       fail,
  output stat_t      stat
);

  logic       err_acc, sent_acc, recv_acc, any_data;
  logic [2:0] cnt_acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_acc  <= 1'b0;
      sent_acc <= 1'b0;
      recv_acc <= 1'b0;
      any_data <= 1'b0;
      cnt_acc  <= '0;
      stat     <= '0;
    end else if (start) begin
      err_acc  <= 1'b0;
      sent_acc <= 1'b0;
      recv_acc <= 1'b0;
      any_data <= 1'b0;
      cnt_acc  <= '0;
    end else begin
      if (fail)
        err_acc <= 1'b1;
      if (byte_done) begin
        recv_acc <= recv_acc ^ (^byte_val);
        if (is_data) begin
          cnt_acc  <= cnt_acc + 3'd1;
          any_data <= 1'b1;
          if (is_read)
            sent_acc <= sent_acc ^ (^sent_byte);
        end
      end
      if (finish) begin
        stat.rdy_err  <= err_acc | fail;
        stat.sent_par <= sent_acc;
        stat.recv_par <= recv_acc;
        stat.cnt      <= any_data ? cnt_acc : 3'b111;
        stat.rsvd     <= 2'b00;
      end
    end
  end

endmodule

// File: rtl/spi_stat_slave.sv
module spi_stat_slave
  import spi_stat_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] WIN_BASE = 16'h0040,
  parameter int          WIN_LG   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              safe_mode,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ready,
  output logic [7:0]        cmd_reg
);

  localparam int FIELD_W = 16;

  logic rise, fall, cs_start, cs_end, sel, mosi_s;
  logic rise_g, fall_g, start_g, end_g;

  spi_stat_sync u_sync (
    .clk      (clk),
    .rst      (rst),
    .sck      (sck),
    .cs_n     (cs_n),
    .mosi     (mosi),
    .sck_rise (rise),
    .sck_fall (fall),
    .cs_start (cs_start),
    .cs_end   (cs_end),
    .sel      (sel),
    .mosi_s   (mosi_s)
  );

  assign rise_g  = en & rise;
  assign fall_g  = en & fall;
  assign start_g = en & cs_start;
  assign end_g   = en & cs_end;

  logic       byte_done;
  logic [7:0] byte_val;
  phase_e     ph;
  logic [2:0] bit_cnt;

  spi_stat_frame u_frame (
    .clk       (clk),
    .rst       (rst),
    .start     (start_g),
    .rise      (rise_g),
    .sel       (sel),
    .mosi_s    (mosi_s),
    .byte_done (byte_done),
    .byte_val  (byte_val),
    .ph        (ph),
    .bit_cnt   (bit_cnt)
  );

  logic [FIELD_W-1:0] addr;
  logic [FIELD_W-1:0] req_addr;
  logic [7:0]         tx_sh, tx_cur;
  logic               fail, blocked;
  stat_t              stat;

  assign fail    = (mem_rd | mem_wr) & ~mem_ready;
  assign blocked = safe_mode & ~in_window(addr, WIN_BASE, WIN_LG);

  spi_stat_tally u_tally (
    .clk       (clk),
    .rst       (rst),
    .start     (start_g),
    .finish    (end_g),
    .byte_done (byte_done),
    .byte_val  (byte_val),
    .is_data   (ph == PH_DATA),
    .is_read   (cmd_reg[7]),
    .sent_byte (tx_cur),
    .fail      (fail),
    .stat      (stat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr      <= '0;
      req_addr  <= '0;
      tx_sh     <= '0;
      tx_cur    <= '0;
      cmd_reg   <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      mem_rd <= 1'b0;
      mem_wr <= 1'b0;
      if (start_g) begin
        tx_sh  <= stat;
        tx_cur <= '0;
      end else begin
        if (sel && fall_g && bit_cnt != 3'd0)
          tx_sh <= {tx_sh[6:0], 1'b0};
        if (byte_done) begin
          tx_sh <= '0;
          unique case (ph)
            PH_CMD:    cmd_reg <= byte_val;
            PH_ADR_HI: addr[15:8] <= byte_val;
            PH_ADR_LO: begin
              if (cmd_reg[7]) begin
                mem_rd   <= 1'b1;
                req_addr <= {addr[15:8], byte_val};
                addr     <= {addr[15:8], byte_val} + 16'd1;
              end else begin
                addr <= {addr[15:8], byte_val};
              end
            end
            PH_DATA: begin
              req_addr <= addr;
              addr     <= addr + 16'd1;
              if (cmd_reg[7]) begin
                mem_rd <= 1'b1;
              end else begin
                mem_wdata <= byte_val;
                mem_wr    <= ~blocked;
              end
            end
            default: ;
          endcase
        end
        if (mem_rd) begin
          tx_sh  <= mem_ready ? mem_rdata : 8'h00;
          tx_cur <= mem_ready ? mem_rdata : 8'h00;
        end
      end
    end
  end

  assign mem_addr = req_addr[ADDR_W-1:0];
  assign miso     = en & sel & tx_sh[7];

endmodule

// File: rtl/spi_stat_chk.sv
module spi_stat_chk
  import spi_stat_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] WIN_BASE = 16'h0040,
  parameter int          WIN_LG   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              safe_mode,
  input logic              cs_n,
  input logic              miso,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [7:0]        cmd_reg
);

  a_r3_rw_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> !mem_wr);

  a_r9_safe_window: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && $past(safe_mode)) |-> in_window(16'(mem_addr), WIN_BASE, WIN_LG));

  a_r10_no_access: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!mem_rd && !mem_wr));

  a_r10_cmd_held: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cmd_reg));

  a_r2_miso_idle: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n)) |-> !miso);

endmodule

bind spi_stat_slave spi_stat_chk #(
  .ADDR_W   (ADDR_W),
  .WIN_BASE (WIN_BASE),
  .WIN_LG   (WIN_LG)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .safe_mode (safe_mode),
  .cs_n      (cs_n),
  .miso      (miso),
  .mem_addr  (mem_addr),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .cmd_reg   (cmd_reg)
);

// File: tb/spi_stat_slave_bench.sv
module spi_stat_slave_bench;

  localparam logic [15:0] WB   = 16'h0040;
  localparam int          HALF = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b1;
  logic        safe_mode = 1'b0;
  logic        sck = 1'b0;
  logic        cs_n = 1'b1;
  logic        mosi = 1'b0;
  logic        miso;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_ready = 1'b1;
  logic [7:0]  cmd_reg;

  always #4 clk = ~clk;

  spi_stat_slave u_spi_stat_slave (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .safe_mode (safe_mode),
    .sck       (sck),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .miso      (miso),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ready (mem_ready),
    .cmd_reg   (cmd_reg)
  );

  logic [7:0] mem [0:255];
  logic [7:0] exp_mem [0:255];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
    end else if (mem_wr && mem_ready) begin
      mem[mem_addr[7:0]] <= mem_wdata;
    end
  end
  assign mem_rdata = mem[mem_addr[7:0]];

  int         checks = 0;
  int         fails = 0;
  logic       done = 1'b0;
  logic [7:0] wbuf [0:15];
  logic [7:0] rbuf [0:15];
  logic [7:0] xbuf [0:15];
  logic [7:0] exp_prev = 8'h00;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [15:0] a,
                      input int nhdr, input int n, output logic [7:0] st);
    logic [7:0] d;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    xbyte(cmd, st);
    if (nhdr > 1) xbyte(a[15:8], d);
    if (nhdr > 2) xbyte(a[7:0], d);
    for (int k = 0; k < n; k++) xbyte(wbuf[k], rbuf[k]);
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // One transaction: expectation from the requirements, then field checks.
  task automatic run(input logic [7:0] cmd, input logic [15:0] a,
                     input int nhdr, input int n, input string mreq);
    logic [7:0]  st, ec;
    logic        err, rpar, wpar, full, rd, blk;
    logic [7:0]  old_cmd;
    logic [15:0] ad;
    int          bad;
    old_cmd = cmd_reg;
    full = (nhdr == 3);
    rd   = cmd[7];
    err = 1'b0; rpar = 1'b0;
    wpar = ^cmd;
    if (nhdr > 1) wpar ^= ^a[15:8];
    if (nhdr > 2) wpar ^= ^a[7:0];
    for (int k = 0; k < n; k++) wpar ^= ^wbuf[k];
    if (en) begin
      if (full && rd) begin
        if (!mem_ready) err = 1'b1;
        for (int k = 0; k < n; k++) begin
          xbuf[k] = mem_ready ? exp_mem[8'(a + 16'(k))] : 8'h00;
          rpar ^= ^xbuf[k];
        end
      end
      if (full && !rd) begin
        for (int k = 0; k < n; k++) begin
          ad  = a + 16'(k);
          blk = safe_mode && ((ad >> 4) != (WB >> 4));
          if (!blk) begin
            if (mem_ready) exp_mem[ad[7:0]] = wbuf[k];
            else err = 1'b1;
          end
        end
      end
    end
    ec = {err, rpar, wpar, (n > 0) ? 3'(n) : 3'b111, 2'b00};
    xfer(cmd, a, nhdr, n, st);
    if (en) begin
      chk("R5 status ready error", {31'd0, st[7]}, {31'd0, exp_prev[7]});
      chk("R6 status sent parity", {31'd0, st[6]}, {31'd0, exp_prev[6]});
      chk("R7 status received parity", {31'd0, st[5]}, {31'd0, exp_prev[5]});
      chk("R8 status data count", {29'd0, st[4:2]}, {29'd0, exp_prev[4:2]});
      chk("R2 status low bits", {30'd0, st[1:0]}, 32'd0);
      chk("R1 command register", {24'd0, cmd_reg}, {24'd0, cmd});
      if (full && rd)
        for (int k = 0; k < n; k++)
          chk("R4 read data", {24'd0, rbuf[k]}, {24'd0, xbuf[k]});
      exp_prev = ec;
    end else begin
      chk("R10 miso low while disabled", {24'd0, st}, 32'd0);
      chk("R10 command register held", {24'd0, cmd_reg}, {24'd0, old_cmd});
    end
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(mreq, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i * 7 + 3);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cmd_reg reset", {24'd0, cmd_reg}, 32'd0);
    chk("R2 miso reset", {31'd0, miso}, 32'd0);
    chk("R3 no strobe at reset", {30'd0, mem_rd, mem_wr}, 32'd0);

    // Write bursts 0..10 bytes: R3, R7, R8 count wrap
    for (int n = 0; n <= 10; n++) begin
      for (int k = 0; k < 16; k++) wbuf[k] = 8'(n * 13 + k * 29 + 1);
      run({1'b0, 7'(n * 5 + 1)}, 16'h0080 + 16'(n * 11), 3, n, "R3 memory after write");
    end
    // Read bursts 0..10 bytes: R4, R6, R8
    for (int n = 0; n <= 10; n++) begin
      for (int k = 0; k < 16; k++) wbuf[k] = 8'(n * 3 + k);
      run({1'b1, 7'(n)}, 16'h0080 + 16'(n * 9), 3, n, "R4 memory untouched by read");
    end
    // Short transactions without a data phase: R8 reports 111
    for (int h = 1; h <= 3; h++) begin
      run(8'h05, 16'h12A0, h, 0, "R8 memory after short write");
      run(8'h9C, 16'h0011, h, 0, "R8 memory after short read");
    end
    // Memory stalled: R5
    mem_ready = 1'b0;
    for (int k = 0; k < 16; k++) wbuf[k] = 8'(k + 8'hA0);
    run(8'h01, 16'h0030, 3, 3, "R5 memory after stalled write");
    run(8'h81, 16'h0030, 3, 2, "R5 memory after stalled read");
    safe_mode = 1'b1;
    run(8'h02, 16'h00F0, 3, 2, "R9 stalled fully blocked write");
    mem_ready = 1'b1;
    // Safe mode window edges: R9
    run(8'h03, WB - 16'd2, 3, 5, "R9 write entering window");
    run(8'h04, WB + 16'd14, 3, 4, "R9 write leaving window");
    run(8'h06, 16'h00F0, 3, 2, "R9 write outside window");
    run(8'h07, WB, 3, 16, "R9 write across whole window");
    safe_mode = 1'b0;
    run(8'h87, WB - 16'd2, 3, 6, "R9 read back after safe writes");
    // Disabled port: R10
    en = 1'b0;
    run(8'h3E, 16'h0090, 3, 4, "R10 memory unchanged while disabled");
    en = 1'b1;
    run(8'h00, 16'h0000, 1, 0, "R10 status kept across disabled transaction");
    run(8'h00, 16'h0000, 1, 0, "R2 final status fetch");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule